// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor with Watchdog

This block generates the system reset for a processor that runs from two supply rails. It takes two already-digitized "rail good" flags (one per rail, synchronous to the block clock), an active-low manual reset request, a watchdog kick line and a watchdog enable. From these it drives a reset signal in both polarities. Reset is held for as long as any rail is low or the manual request is active. It then stays asserted for a fixed release interval once every condition has cleared.

A watchdog timer guards software liveness. Software services it by toggling the kick line, and a change in either direction counts as a service. If the timer reaches its timeout without a service, the block issues a reset pulse as long as the release interval, and the timer restarts from zero once that pulse ends. The manual request and the kick line are asynchronous to the block clock, so each passes through a multi-stage synchronizer first. The release interval and the timeout are cycle-count parameters. At a 32 kHz clock, the defaults correspond to 200 ms and 1.6 s.

Top module: `rail_reset_supervisor`

## Requirements
- R1: Reset is released only when the manual request is high and both rail-good flags are 1; with only one rail good, reset stays asserted indefinitely.
- R2: Once all conditions are clear, reset deasserts after exactly HOLD_CYCLES clock edges that sample the rails good (plus SYNC_STAGES edges when the manual request was the last condition to clear).
- R3: A rail-good flag sampled at 0 asserts reset on the next clock edge, with no delay interval.
- R4: If a reset condition returns while the release interval is running, the interval restarts from zero after the condition clears again.
- R5: Both a 0-to-1 and a 1-to-0 change on the kick line restart the watchdog timer.
- R6: When the watchdog is enabled and reaches WDOG_CYCLES cycles without a kick change, reset is asserted for exactly HOLD_CYCLES cycles.
- R7: After a watchdog-caused reset ends, the timer starts again from zero, so a kick-less system sees reset low for exactly WDOG_CYCLES+1 cycles between pulses.
- R8: A manual request held low asserts reset within SYNC_STAGES+1 edges; after it returns high, reset is released HOLD_CYCLES+SYNC_STAGES edges later.
- R9: The active-low output is always the complement of the active-high output.
- R10: With the watchdog enable low, the watchdog never causes a reset, however long the kick line stays still.
- R11: The watchdog timer is held at zero while reset is asserted for any cause, so after a long rail-caused reset the first timeout is still a full WDOG_CYCLES+1 cycles of released reset.
- R12: While the block's own power-on reset is low, and directly after it, the system reset is asserted (sys_rst_o = 1, sys_rst_no = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running block clock |
| por_ni | input | 1 | Asynchronous power-on reset of the block, active low |
| rail_a_ok_i | input | 1 | First rail above its threshold, synchronous |
| rail_b_ok_i | input | 1 | Second rail above its threshold, synchronous |
| man_rst_ni | input | 1 | Manual reset request, active low, asynchronous |
| kick_i | input | 1 | Watchdog service line; either edge services |
| wdog_en_i | input | 1 | Watchdog enable; low disables expiry |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The checker assumes that the rail flags are already synchronous to clk_i and are driven from the power-on reset onward, so that their one-cycle path to reset can be checked with `|=>`. It also assumes that the watchdog enable has a defined level in every cycle. The manual request is checked only through its synchronized copy, because the raw pin may change at any time. The bench drives every input on the falling clock edge, which keeps the rail flags settled before the sampling edge. It moves the manual and kick lines only a few cycles at a time, with gaps far wider than the synchronizer depth.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Every reason that can hold the system in reset.
   typedef struct packed {
      logic rail_a_low;
      logic rail_b_low;
      logic manual;
      logic wdog;
   } hold_cause_t;

   function automatic logic cause_any(input hold_cause_t c);
      return c.rail_a_low | c.rail_b_low | c.manual | c.wdog;
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int unsigned            W       = 1,
   parameter int unsigned            STAGES  = 2,
   parameter logic [W-1:0]           RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] src;
      if (s == 0) begin : g_first
         assign src = d_i;
      end else begin : g_next
         assign src = stg_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q[s] <= RST_VAL;
         else         stg_q[s] <= src;
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sup_release_timer.sv
module sup_release_timer
   import sup_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 6400
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  hold_cause_t cause_i,
   output logic        rst_o,
   output logic        rst_no
);

   localparam int unsigned CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          rst_q;
   logic          rst_nq;
   logic          hold;

   assign hold = cause_any(cause_i);

   // Two output flops, each driving one polarity, loaded with opposite values.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         rst_q  <= 1'b1;
         rst_nq <= 1'b0;
      end else if (hold) begin
         cnt_q  <= '0;
         rst_q  <= 1'b1;
         rst_nq <= 1'b0;
      end else if (rst_q) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            rst_q  <= 1'b0;
            rst_nq <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign rst_o  = rst_q;
   assign rst_no = rst_nq;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int unsigned WDOG_CYCLES = 51200
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic hold_i,
   input  logic kick_i,
   output logic fire_o
);

   localparam int unsigned CW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          kick_prev_q;
   logic          kick_edge;
   logic          fire_q;

   assign kick_edge = kick_i ^ kick_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) kick_prev_q <= 1'b0;
      else         kick_prev_q <= kick_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (!en_i || hold_i || kick_edge) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q  <= '0;
         fire_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         fire_q <= 1'b0;
      end
   end

   assign fire_o = fire_q;

endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
   import sup_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 6400,
   parameter int unsigned WDOG_CYCLES = 51200,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic rail_a_ok_i,
   input  logic rail_b_ok_i,
   input  logic man_rst_ni,
   input  logic kick_i,
   input  logic wdog_en_i,
   output logic sys_rst_o,
   output logic sys_rst_no
);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("rail_reset_supervisor: HOLD_CYCLES must be at least 2");
   end
   if (WDOG_CYCLES < 2) begin : g_bad_wdog
      $error("rail_reset_supervisor: WDOG_CYCLES must be at least 2");
   end

   logic [1:0]  async_s;
   logic        man_sync;
   logic        kick_sync;
   logic        wd_fire;
   logic        rst_int;
   hold_cause_t cause;

   // Manual request resets to "pressed" so reset holds until it is seen high.
   sup_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b00)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (por_ni),
      .d_i    ({man_rst_ni, kick_i}),
      .q_o    (async_s)
   );

   assign man_sync  = async_s[1];
   assign kick_sync = async_s[0];

   assign cause.rail_a_low = ~rail_a_ok_i;
   assign cause.rail_b_low = ~rail_b_ok_i;
   assign cause.manual     = ~man_sync;
   assign cause.wdog       = wd_fire;

   sup_release_timer #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) rel_i (
      .clk_i   (clk_i),
      .rst_ni  (por_ni),
      .cause_i (cause),
      .rst_o   (rst_int),
      .rst_no  (sys_rst_no)
   );

   sup_wdog #(
      .WDOG_CYCLES (WDOG_CYCLES)
   ) wd_i (
      .clk_i  (clk_i),
      .rst_ni (por_ni),
      .en_i   (wdog_en_i),
      .hold_i (rst_int),
      .kick_i (kick_sync),
      .fire_o (wd_fire)
   );

   assign sys_rst_o = rst_int;

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
   parameter int unsigned HOLD_CYCLES = 6400
) (
   input logic clk_i,
   input logic por_ni,
   input logic rail_a_ok_i,
   input logic rail_b_ok_i,
   input logic wdog_en_i,
   input logic man_sync,
   input logic wd_fire,
   input logic sys_rst_o,
   input logic sys_rst_no
);

   localparam int unsigned RW = $clog2(HOLD_CYCLES + 1);
   localparam logic [RW-1:0] RMAX = RW'(HOLD_CYCLES);

   logic          cond;
   logic [RW-1:0] run_q;

   assign cond = !rail_a_ok_i || !rail_b_ok_i || !man_sync || wd_fire;

   // Cycles in a row with no hold reason, saturating at the release interval.
   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)          run_q <= '0;
      else if (cond)        run_q <= '0;
      else if (run_q != RMAX) run_q <= run_q + 1'b1;
   end

   AST_RAIL_DROP: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!rail_a_ok_i || !rail_b_ok_i) |=> sys_rst_o); // R3

   AST_RELEASE_DELAY: assert property (@(posedge clk_i) disable iff (!por_ni)
      $fell(sys_rst_o) |-> (run_q == RMAX)); // R2

   AST_RELEASE_COND: assert property (@(posedge clk_i) disable iff (!por_ni)
      $fell(sys_rst_o) |-> ($past(rail_a_ok_i) && $past(rail_b_ok_i) && $past(man_sync))); // R1

   AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!por_ni)
      !man_sync |=> sys_rst_o); // R8

   AST_WDOG_OFF: assert property (@(posedge clk_i) disable iff (!por_ni)
      !wdog_en_i |=> !wd_fire); // R10

   AST_WDOG_HELD: assert property (@(posedge clk_i) disable iff (!por_ni)
      sys_rst_o |=> !wd_fire); // R11

   AST_OUT_PAIR: assert property (@(posedge clk_i) disable iff (!por_ni)
      sys_rst_o != sys_rst_no); // R9

endmodule

bind rail_reset_supervisor sup_checker #(
   .HOLD_CYCLES (HOLD_CYCLES)
) chk_i (
   .clk_i       (clk_i),
   .por_ni      (por_ni),
   .rail_a_ok_i (rail_a_ok_i),
   .rail_b_ok_i (rail_b_ok_i),
   .wdog_en_i   (wdog_en_i),
   .man_sync    (man_sync),
   .wd_fire     (wd_fire),
   .sys_rst_o   (sys_rst_o),
   .sys_rst_no  (sys_rst_no)
);

// File: tb/rail_reset_supervisor_tb_top.sv
module rail_reset_supervisor_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  HOLD = 20;
   localparam int  WDOG = 60;
   localparam int  SYNC = 2;

   logic clk = 1'b0;
   logic por_ni = 1'b0;
   logic rail_a = 1'b0;
   logic rail_b = 1'b0;
   logic man_n = 1'b1;
   logic kick = 1'b0;
   logic wd_en = 1'b0;
   logic rst_o;
   logic rst_no;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_reset_supervisor #(
      .HOLD_CYCLES (HOLD),
      .WDOG_CYCLES (WDOG),
      .SYNC_STAGES (SYNC)
   ) dut_i (
      .clk_i       (clk),
      .por_ni      (por_ni),
      .rail_a_ok_i (rail_a),
      .rail_b_ok_i (rail_b),
      .man_rst_ni  (man_n),
      .kick_i      (kick),
      .wdog_en_i   (wd_en),
      .sys_rst_o   (rst_o),
      .sys_rst_no  (rst_no)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_rst(input string req, input logic exp);
      check(rst_o === exp, req, int'(rst_o), int'(exp));
      check(rst_no === ~exp, {req, "/R9"}, int'(rst_no), int'(~exp));
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Steps n cycles and reports whether reset was seen high at any sample.
   task automatic watch_low(input int n, output bit saw);
      saw = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_o !== 1'b0) saw = 1'b1;
      end
   endtask

   task automatic wait_for(input logic lvl, input int limit, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < limit; i++) begin
         if (rst_o === lvl) begin
            ok = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (rst_o === lvl && n < 10000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_power_on();
      step(3);
      check_rst("R12 during por", 1'b1);
      por_ni = 1'b1;
      step(3);
      check_rst("R12 after por", 1'b1);
   endtask

   task automatic t_rail_release();
      rail_a = 1'b1;
      step(3 * HOLD);
      check_rst("R1 one rail good", 1'b1);
      rail_b = 1'b1;
      step(HOLD - 1);
      check_rst("R2 before interval", 1'b1);
      step(1);
      check_rst("R2 at interval", 1'b0);
   endtask

   task automatic t_rail_drop();
      rail_b = 1'b0;
      step(1);
      check_rst("R3 rail drop", 1'b1);
      rail_b = 1'b1;
      step(HOLD / 2);
      check_rst("R4 mid interval", 1'b1);
      rail_a = 1'b0;
      step(1);
      rail_a = 1'b1;
      step(HOLD - 1);
      check_rst("R4 restarted, before", 1'b1);
      step(1);
      check_rst("R4 restarted, at", 1'b0);
   endtask

   task automatic t_manual();
      man_n = 1'b0;
      step(SYNC + 1);
      check_rst("R8 manual assert", 1'b1);
      step(3);
      man_n = 1'b1;
      step(HOLD + SYNC - 1);
      check_rst("R8 before release", 1'b1);
      step(1);
      check_rst("R8 at release", 1'b0);
   endtask

   task automatic t_wdog_off();
      bit saw;
      wd_en = 1'b0;
      watch_low(3 * WDOG, saw);
      check(!saw, "R10 disabled watchdog", int'(saw), 0);
   endtask

   task automatic t_kicks();
      bit saw;
      bit any = 1'b0;
      wd_en = 1'b1;
      // Gap is 2/3 of the timeout, so one edge direction alone would expire.
      for (int i = 0; i < 9; i++) begin
         watch_low(40, saw);
         any |= saw;
         kick = ~kick;
      end
      watch_low(40, saw);
      any |= saw;
      check(!any, "R5 both kick edges service", int'(any), 0);
   endtask

   task automatic t_expiry();
      bit ok;
      int n;
      wait_for(1'b1, 3 * WDOG, ok);
      check(ok, "R6 expiry seen", int'(ok), 1);
      run_len(1'b1, n);
      check(n == HOLD, "R6 pulse length", n, HOLD);
      run_len(1'b0, n);
      check(n == WDOG + 1, "R7 restart after pulse", n, WDOG + 1);
      run_len(1'b1, n);
      check(n == HOLD, "R6 second pulse length", n, HOLD);
   endtask

   task automatic t_held();
      int n;
      rail_a = 1'b0;
      step(2 * WDOG);
      check_rst("R11 long rail reset", 1'b1);
      rail_a = 1'b1;
      step(HOLD - 1);
      check_rst("R2 after long reset", 1'b1);
      step(1);
      check_rst("R2 release after long reset", 1'b0);
      run_len(1'b0, n);
      check(n == WDOG + 1, "R11 timer held in reset", n, WDOG + 1);
      wd_en = 1'b0;
   endtask

   initial begin
      t_power_on();
      t_rail_release();
      t_rail_drop();
      t_manual();
      t_wdog_off();
      t_kicks();
      t_expiry();
      t_held();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule